// File: doc/BRIEF.md
# Threshold FIFO Pair with Interrupt Status

This block sits between a host register port and a byte-serial shift engine. It holds two byte queues: one carries bytes from the host toward the shifter, the other carries bytes received by the shifter back to the host. Each queue tracks how many bytes it holds, and each has a programmable watermark that raises a sticky status flag. The flags are the receive-ready and transmit-request conditions, a receive-overflow event and a transfer-complete event. They are gathered into one status word. Each flag has its own enable bit, and one interrupt line is driven from the enabled flags.

Software programs both watermarks and can flush either queue through one control word. It reads both occupancy counts from a status word. It enables interrupt sources in one register and clears pending flags by writing ones to a second register that has the same bit layout. The shift engine pops transmit bytes, pushes received bytes and pulses a done input at the end of a transfer. The queue depth is a parameter (64 by default, 128 also supported).

Top module: `fifo_pair_irq`

## Requirements
- R1: After reset both counts read zero, the enable register reads zero, the interrupt output is low, and both watermarks read back as three quarters of the depth (0x0030_0030 for depth 64).
- R2: Bytes that the host pushes toward the shifter leave at the shifter side in the order they were written, and the transmit count follows each push and pop.
- R3: A push into a full queue is dropped and the count stays at the depth. A pop from an empty queue leaves the count at zero.
- R4: Bytes that the shifter pushes leave at the host side in arrival order, and the receive count follows each push and pop.
- R5: The control word (register address 0) holds the receive watermark in bits 7:0 and the transmit watermark in bits 23:16. Writing 1 to bit 15 empties the receive queue only, and writing 1 to bit 31 empties the transmit queue only. These two bits read back as zero.
- R6: Receive-ready (status bit 0) sets when the receive count is at or above the receive watermark.
- R7: Transmit-request (status bit 4) sets when the transmit count is at or below the transmit watermark.
- R8: Receive-overflow (status bit 8) sets when the shifter pushes a byte while the receive queue is full. That byte is discarded.
- R9: Transfer-complete (status bit 12) sets one cycle after a pulse on the done input.
- R10: Writing 1 to a status bit (register address 3) clears it on that clock edge, and writing 0 leaves it unchanged. A level flag whose condition still holds sets again on the following edge.
- R11: An overflow or done event in the same cycle as a clear of its own bit leaves that bit set.
- R12: The interrupt output is high exactly when some status bit and its enable bit (register address 2, same layout as the status word) are both set.
- R13: The count word (register address 1) gives the receive count from bit 0 and the transmit count from bit 16. The enable and status registers implement only bits 0, 4, 8 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 counts, 2 enable, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| host_tx_push | input | 1 | Host writes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_pop | input | 1 | Host removes a byte from the receive queue |
| host_rx_data | output | 8 | Oldest byte in the receive queue |
| sh_tx_pop | input | 1 | Shifter removes a byte from the transmit queue |
| sh_tx_data | output | 8 | Oldest byte in the transmit queue |
| sh_tx_empty | output | 1 | Transmit queue is empty |
| sh_rx_push | input | 1 | Shifter delivers a received byte |
| sh_rx_data | input | 8 | Received byte |
| sh_rx_full | output | 1 | Receive queue is full |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the properties that hold locally. Occupancy never exceeds the depth, a flush empties a queue on the next edge, and a push into a full queue leaves the count unchanged. Each watermark or event condition sets its flag one edge later unless a clear intervenes. A clear of a level flag takes effect, and with no enables set the interrupt line stays low. Byte ordering through both queues cannot be seen by those properties, and neither can the independence of the two flush bits, the loss of the overflowing byte, the re-setting of a cleared level flag or the register field layout. Only the bench's sequences show these.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  typedef enum logic [1:0] {
    ADDR_FCTL = 2'd0,
    ADDR_FSTA = 2'd1,
    ADDR_IEN  = 2'd2,
    ADDR_ISTA = 2'd3
  } reg_addr_e;

  localparam int WORD_W      = 32;
  localparam int TRIG_W      = 8;
  localparam int RXTRIG_LSB  = 0;
  localparam int RXFLUSH_BIT = 15;
  localparam int TXTRIG_LSB  = 16;
  localparam int TXFLUSH_BIT = 31;
  localparam int RXCNT_LSB   = 0;
  localparam int TXCNT_LSB   = 16;

  // interrupt source index; register bit = 4 * index
  localparam int EV_RXRDY = 0;
  localparam int EV_TXREQ = 1;
  localparam int EV_RXOVF = 2;
  localparam int EV_DONE  = 3;
  localparam int NUM_EV   = 4;
  localparam int EV_STRIDE = 4;

  function automatic logic [WORD_W-1:0] ev_to_word(input logic [NUM_EV-1:0] ev);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_EV; i++) w[EV_STRIDE*i] = ev[i];
    return w;
  endfunction

  function automatic logic [NUM_EV-1:0] word_to_ev(input logic [WORD_W-1:0] w);
    logic [NUM_EV-1:0] ev;
    for (int i = 0; i < NUM_EV; i++) ev[i] = w[EV_STRIDE*i];
    return ev;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign count   = cnt_q;
  assign rdata   = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_d = rd_ptr_q + AW'(1);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage array: write enable only, no reset
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem_q[wr_ptr_q] <= wdata;
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/fifo_regs.sv
module fifo_regs
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [TRIG_W-1:0] rx_trig,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [NUM_EV-1:0] ien,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic [NUM_EV-1:0] sta_clr
);

  localparam logic [TRIG_W-1:0] TRIG_RST = TRIG_W'(DEPTH / 4 * 3);

  logic [TRIG_W-1:0] rx_trig_q, rx_trig_d;
  logic [TRIG_W-1:0] tx_trig_q, tx_trig_d;
  logic [NUM_EV-1:0] ien_q, ien_d;
  logic              fctl_en, ien_en, ista_en;

  assign fctl_en = wr && (addr == ADDR_FCTL);
  assign ien_en  = wr && (addr == ADDR_IEN);
  assign ista_en = wr && (addr == ADDR_ISTA);

  always_comb begin
    rx_trig_d = rx_trig_q;
    tx_trig_d = tx_trig_q;
    ien_d     = ien_q;
    if (fctl_en) begin
      rx_trig_d = wdata[RXTRIG_LSB +: TRIG_W];
      tx_trig_d = wdata[TXTRIG_LSB +: TRIG_W];
    end
    if (ien_en) ien_d = word_to_ev(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig_q <= TRIG_RST;
      tx_trig_q <= TRIG_RST;
      ien_q     <= '0;
    end else begin
      rx_trig_q <= rx_trig_d;
      tx_trig_q <= tx_trig_d;
      ien_q     <= ien_d;
    end
  end

  assign rx_trig  = rx_trig_q;
  assign tx_trig  = tx_trig_q;
  assign ien      = ien_q;
  assign rx_flush = fctl_en && wdata[RXFLUSH_BIT];
  assign tx_flush = fctl_en && wdata[TXFLUSH_BIT];
  assign sta_clr  = ista_en ? word_to_ev(wdata) : '0;

endmodule

// File: rtl/irq_status.sv
module irq_status
  import fifo_irq_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     rx_count,
  input  logic [CW-1:0]     tx_count,
  input  logic [TRIG_W-1:0] rx_trig,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic              rx_push,
  input  logic              rx_full,
  input  logic              xfer_done,
  input  logic [NUM_EV-1:0] clr,
  input  logic [NUM_EV-1:0] ien,
  output logic [NUM_EV-1:0] sta,
  output logic              irq
);

  localparam int CMP_W = ((CW > TRIG_W) ? CW : TRIG_W) + 1;

  logic [NUM_EV-1:0] cond;
  logic [NUM_EV-1:0] sta_q, sta_d;

  assign cond[EV_RXRDY] = CMP_W'(rx_count) >= CMP_W'(rx_trig);
  assign cond[EV_TXREQ] = CMP_W'(tx_count) <= CMP_W'(tx_trig);
  assign cond[EV_RXOVF] = rx_push & rx_full;
  assign cond[EV_DONE]  = xfer_done;

  // level sources: a clear wins and the flag re-arms next edge
  // pulse sources: a new event wins so it is never lost
  for (genvar i = 0; i < NUM_EV; i++) begin : g_src
    if (i == EV_RXRDY || i == EV_TXREQ) begin : g_level
      always_comb sta_d[i] = clr[i] ? 1'b0 : (sta_q[i] | cond[i]);
    end else begin : g_pulse
      always_comb sta_d[i] = (sta_q[i] & ~clr[i]) | cond[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sta_q <= '0;
    else        sta_q <= sta_d;
  end

  assign sta = sta_q;
  assign irq = |(sta_q & ien);

  assert_rxrdy_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (CMP_W'(rx_count) >= CMP_W'(rx_trig) && !clr[EV_RXRDY]) |=> sta[EV_RXRDY]);

  assert_txreq_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (CMP_W'(tx_count) <= CMP_W'(tx_trig) && !clr[EV_TXREQ]) |=> sta[EV_TXREQ]);

  assert_overflow_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> sta[EV_RXOVF]);

  assert_done_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> sta[EV_DONE]);

  assert_level_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr[EV_RXRDY] |=> !sta[EV_RXRDY]);

  assert_masked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

endmodule

// File: rtl/fifo_pair_irq.sv
module fifo_pair_irq
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        host_tx_push,
  input  logic [7:0]  host_tx_data,
  input  logic        host_rx_pop,
  output logic [7:0]  host_rx_data,
  input  logic        sh_tx_pop,
  output logic [7:0]  sh_tx_data,
  output logic        sh_tx_empty,
  input  logic        sh_rx_push,
  input  logic [7:0]  sh_rx_data,
  output logic        sh_rx_full,
  input  logic        xfer_done,
  output logic        irq
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [TRIG_W-1:0] rx_trig, tx_trig;
  logic [NUM_EV-1:0] ien, sta, sta_clr;
  logic              rx_flush, tx_flush;
  logic [CW-1:0]     rx_cnt, tx_cnt;
  logic              tx_full, rx_empty;

  fifo_regs #(.DEPTH(DEPTH)) i_regs (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rx_trig  (rx_trig),
    .tx_trig  (tx_trig),
    .ien      (ien),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush),
    .sta_clr  (sta_clr)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) i_tx_fifo (
    .clk   (clk),
    .rst_n (rst_ni),
    .flush (tx_flush),
    .push  (host_tx_push),
    .wdata (host_tx_data),
    .pop   (sh_tx_pop),
    .rdata (sh_tx_data),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (sh_tx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) i_rx_fifo (
    .clk   (clk),
    .rst_n (rst_ni),
    .flush (rx_flush),
    .push  (sh_rx_push),
    .wdata (sh_rx_data),
    .pop   (host_rx_pop),
    .rdata (host_rx_data),
    .count (rx_cnt),
    .full  (sh_rx_full),
    .empty (rx_empty)
  );

  irq_status #(.CW(CW)) i_irq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .rx_count  (rx_cnt),
    .tx_count  (tx_cnt),
    .rx_trig   (rx_trig),
    .tx_trig   (tx_trig),
    .rx_push   (sh_rx_push),
    .rx_full   (sh_rx_full),
    .xfer_done (xfer_done),
    .clr       (sta_clr),
    .ien       (ien),
    .sta       (sta),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_FCTL: begin
        reg_rdata[RXTRIG_LSB +: TRIG_W] = rx_trig;
        reg_rdata[TXTRIG_LSB +: TRIG_W] = tx_trig;
      end
      ADDR_FSTA: begin
        reg_rdata[RXCNT_LSB +: CW] = rx_cnt;
        reg_rdata[TXCNT_LSB +: CW] = tx_cnt;
      end
      ADDR_IEN:  reg_rdata = ev_to_word(ien);
      ADDR_ISTA: reg_rdata = ev_to_word(sta);
      default:   reg_rdata = '0;
    endcase
  end

  assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(tx_full && sh_tx_empty) && !(sh_rx_full && rx_empty));

endmodule

// File: tb/test_fifo_pair_irq.sv
module test_fifo_pair_irq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam logic [1:0] OP_TXPUSH = 2'd0, OP_TXPOP = 2'd1, OP_RXPUSH = 2'd2, OP_RXPOP = 2'd3;

  // {op, data, expected tx count, expected rx count}
  localparam logic [25:0] VEC [NVEC] = '{
    {OP_TXPUSH, 8'hA5, 8'd1, 8'd0},
    {OP_TXPUSH, 8'h3C, 8'd2, 8'd0},
    {OP_RXPUSH, 8'h11, 8'd2, 8'd1},
    {OP_TXPUSH, 8'h7E, 8'd3, 8'd1},
    {OP_RXPUSH, 8'h22, 8'd3, 8'd2},
    {OP_TXPOP,  8'hA5, 8'd2, 8'd2},
    {OP_RXPOP,  8'h11, 8'd2, 8'd1},
    {OP_TXPOP,  8'h3C, 8'd1, 8'd1},
    {OP_RXPUSH, 8'h33, 8'd1, 8'd2},
    {OP_RXPOP,  8'h22, 8'd1, 8'd1},
    {OP_TXPOP,  8'h7E, 8'd0, 8'd1},
    {OP_RXPOP,  8'h33, 8'd0, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        host_tx_push, host_rx_pop, sh_tx_pop, sh_rx_push, xfer_done;
  logic [7:0]  host_tx_data, host_rx_data, sh_tx_data, sh_rx_data;
  logic        sh_tx_empty, sh_rx_full, irq;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_pair_irq i_fifo_pair_irq (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
    .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
    .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data), .sh_tx_empty(sh_tx_empty),
    .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data), .sh_rx_full(sh_rx_full),
    .xfer_done(xfer_done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tx_push(input logic [7:0] d);
    host_tx_push = 1'b1; host_tx_data = d; tick(); host_tx_push = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    sh_rx_push = 1'b1; sh_rx_data = d; tick(); sh_rx_push = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    host_tx_push = 1'b0; host_tx_data = '0; host_rx_pop = 1'b0;
    sh_tx_pop = 1'b0; sh_rx_push = 1'b0; sh_rx_data = '0; xfer_done = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    reg_read(2'd1, rd); check(rd == 32'h0, "R1 counts", rd, 32'h0);
    reg_read(2'd2, rd); check(rd == 32'h0, "R1 enables", rd, 32'h0);
    reg_read(2'd0, rd); check(rd == 32'h0030_0030, "R1 watermarks", rd, 32'h0030_0030);
    check(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);

    // R2 R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op;
      logic [7:0] dat, etx, erx;
      {op, dat, etx, erx} = VEC[v];
      case (op)
        OP_TXPUSH: tx_push(dat);
        OP_RXPUSH: rx_push(dat);
        OP_TXPOP: begin
          check(sh_tx_data == dat, "R2 tx order", {24'b0, sh_tx_data}, {24'b0, dat});
          sh_tx_pop = 1'b1; tick(); sh_tx_pop = 1'b0;
        end
        default: begin
          check(host_rx_data == dat, "R4 rx order", {24'b0, host_rx_data}, {24'b0, dat});
          host_rx_pop = 1'b1; tick(); host_rx_pop = 1'b0;
        end
      endcase
      reg_read(2'd1, rd);
      check(rd == {8'b0, etx, 8'b0, erx}, "R2 R4 counts", rd, {8'b0, etx, 8'b0, erx});
    end

    // R10 clear all, level flag re-sets next edge (tx count 0 <= 48)
    reg_write(2'd3, 32'hFFFF_FFFF);
    reg_read(2'd3, rd); check(rd == 32'h0, "R10 clear all", rd, 32'h0);
    tick();
    reg_read(2'd3, rd); check(rd == 32'h10, "R10 R7 re-set", rd, 32'h10);

    // R13 enable layout, R12 irq gating
    reg_write(2'd2, 32'hFFFF_FFFF);
    reg_read(2'd2, rd); check(rd == 32'h1111, "R13 enable bits", rd, 32'h1111);
    check(irq == 1'b1, "R12 irq on", {31'b0, irq}, 32'h1);
    reg_write(2'd2, 32'h0);
    check(irq == 1'b0, "R12 irq masked", {31'b0, irq}, 32'h0);

    // R3 overfill transmit, pop empty receive
    host_tx_push = 1'b1;
    for (int i = 0; i < 70; i++) begin host_tx_data = 8'(i); tick(); end
    host_tx_push = 1'b0;
    reg_read(2'd1, rd); check(rd == 32'h0040_0000, "R3 full count", rd, 32'h0040_0000);
    check(sh_tx_data == 8'h00, "R3 head kept", {24'b0, sh_tx_data}, 32'h0);
    host_rx_pop = 1'b1; tick(); host_rx_pop = 1'b0;
    reg_read(2'd1, rd); check(rd == 32'h0040_0000, "R3 pop empty", rd, 32'h0040_0000);

    // R7 transmit watermark
    reg_write(2'd3, 32'h10);
    tick();
    reg_read(2'd3, rd); check(rd[4] == 1'b0, "R7 above mark", rd, 32'h0);
    sh_tx_pop = 1'b1; repeat (16) tick(); sh_tx_pop = 1'b0;
    tick();
    reg_read(2'd3, rd); check(rd[4] == 1'b1, "R7 at mark", rd, 32'h10);

    // R5 independent flushes
    rx_push(8'h01); rx_push(8'h02); rx_push(8'h03);
    reg_write(2'd0, 32'h8030_0030);
    reg_read(2'd1, rd); check(rd == 32'h0000_0003, "R5 tx flush", rd, 32'h3);
    tx_push(8'h55); tx_push(8'h66);
    reg_write(2'd0, 32'h0030_8030);
    reg_read(2'd1, rd); check(rd == 32'h0002_0000, "R5 rx flush", rd, 32'h0002_0000);
    reg_read(2'd0, rd); check(rd == 32'h0030_0030, "R5 flush bits read 0", rd, 32'h0030_0030);

    // R6 receive watermark at 4
    reg_write(2'd0, 32'h0030_0004);
    rx_push(8'h01); rx_push(8'h02); rx_push(8'h03);
    reg_write(2'd3, 32'h1);
    reg_read(2'd3, rd); check(rd[0] == 1'b0, "R6 below mark", rd, 32'h0);
    rx_push(8'h04);
    tick();
    reg_read(2'd3, rd); check(rd[0] == 1'b1, "R6 at mark", rd, 32'h1);

    // R8 overflow drops the byte
    for (int i = 0; i < 60; i++) rx_push(8'h40 + 8'(i));
    reg_read(2'd3, rd); check(rd[8] == 1'b0, "R8 before overflow", rd, 32'h0);
    rx_push(8'hEE);
    reg_read(2'd3, rd); check(rd[8] == 1'b1, "R8 overflow flag", rd, 32'h100);
    reg_read(2'd1, rd); check(rd[7:0] == 8'd64, "R8 count held", rd, 32'd64);
    host_rx_pop = 1'b1; repeat (63) tick(); host_rx_pop = 1'b0;
    check(host_rx_data == 8'h7B, "R8 byte dropped", {24'b0, host_rx_data}, 32'h7B);

    // R9 done event, R11 event beats clear, R10 zero write
    reg_write(2'd3, 32'h1000);
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    reg_read(2'd3, rd); check(rd[12] == 1'b1, "R9 done flag", rd, 32'h1000);
    reg_write(2'd3, 32'h1000);
    reg_read(2'd3, rd); check(rd[12] == 1'b0, "R10 done cleared", rd, 32'h0);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h1000; xfer_done = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; xfer_done = 1'b0;
    reg_read(2'd3, rd); check(rd[12] == 1'b1, "R11 event wins", rd, 32'h1000);
    reg_write(2'd3, 32'h0);
    reg_read(2'd3, rd); check(rd[12] == 1'b1, "R10 zero write", rd, 32'h1000);
    reg_write(2'd2, 32'h1000);
    check(irq == 1'b1, "R12 done irq", {31'b0, irq}, 32'h1);
    reg_write(2'd3, 32'h1000);
    check(irq == 1'b0, "R12 irq after clear", {31'b0, irq}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule